// File: doc/BRIEF.md
# Multi-Output Bridge PWM Generator

This block produces a pulse-width-modulated waveform with a 10-bit duty resolution and sends it to four output pins. How the waveform reaches the pins depends on an output mode: one pin only, a complementary pair for a half-bridge, a four-pin pattern for a full-bridge with a selectable direction, or any subset of the four pins chosen by a mask. The active level of all pins can be set high or low.

The time base is an 8-bit period counter extended by two low-order bits. It advances once per prescale tick. At the end of each period the count returns to zero and a match strobe pulses. At the same boundary the duty value and all output settings are copied into shadow registers. Software may therefore change any setting at any time, and the waveform changes only at a period edge. After the block is enabled, the pins stay inactive for the rest of the first period. This avoids a truncated first pulse.

Top module: `bridge_pwm`

## Requirements
- R1: When enabled, the 10-bit count advances by one on each cycle with `tick_i` high. On a tick with count equal to {`period_i`, 2'b11}, the count returns to 0 and `match_o` is high in that cycle. One period is therefore (`period_i`+1)*4 ticks. `match_o` is low in every other cycle.
- R2: Once running, the internal PWM level is active while the count is below the shadow duty value {`duty_hi_i`, `duty_lo_i`}. A duty of 0 gives a constant inactive level. A duty above the last count of the period gives a constant active level.
- R3: The duty, `mode_i`, `dir_i`, `pol_i` and `steer_i` are copied into shadow registers only in a cycle where `match_o` is high. Changes made between boundaries have no effect on the pins until the next boundary.
- R4: After `en_i` rises, all pins stay at the inactive level until the first boundary. Output begins with the period that starts there.
- R5: While `en_i` is low, the count is held at 0, `match_o` is low, and every pin sits at the inactive level of the `pol_i` value seen one cycle earlier. While disabled, the shadow registers follow the inputs every cycle.
- R6: `pol_i`=0 makes the active level high. `pol_i`=1 makes the active level low. Each pin equals its logical drive XOR the shadow polarity.
- R7: Mode 2'b00 (single): pin `pwm_o[0]` (A) carries the PWM level. Pins B, C and D (`pwm_o[1]`..`pwm_o[3]`) are inactive.
- R8: Mode 2'b01 (half-bridge): A carries the PWM level and B carries its complement while running. C and D are inactive.
- R9: Mode 2'b10 (full-bridge): with `dir_i`=0, A is held active, D carries the PWM level, and B and C are inactive. With `dir_i`=1, C is held active, B carries the PWM level, and A and D are inactive.
- R10: Mode 2'b11 (steering): pin k carries the PWM level when `steer_i[k]` is 1. Otherwise pin k is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Prescale tick; the count advances when high |
| en_i | input | 1 | Module enable |
| period_i | input | 8 | Period value (high part of the period end) |
| duty_hi_i | input | 8 | Duty value, upper 8 bits |
| duty_lo_i | input | 2 | Duty value, lower 2 bits |
| mode_i | input | 2 | Output mode: 00 single, 01 half, 10 full, 11 steering |
| dir_i | input | 1 | Full-bridge direction: 0 forward, 1 reverse |
| pol_i | input | 1 | Polarity: 0 active high, 1 active low |
| steer_i | input | 4 | Steering mask, bit k enables pin k |
| pwm_o | output | 4 | Output pins A..D on bits 0..3 |
| match_o | output | 1 | Period-boundary strobe |

## Verification
Every output mode is run at a mid-range duty over several periods. This separates the pin maps of the single, half-bridge, both full-bridge directions and two complementary steering masks. Duty values of zero and full scale exercise the two constant-level extremes. A duty change and a direction change are written in mid-period, which shows whether the shadow copy waits for the boundary. Sparse ticks with a different period test the time base apart from the clock. Disable and re-enable sequences with inverted polarity test the inactive level and the deferred first period.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_HALF   = 2'b01,
    MODE_FULL   = 2'b10,
    MODE_STEER  = 2'b11
  } out_mode_e;

  localparam int NUM_PINS = 4;
endpackage

// File: rtl/bpwm_timebase.sv
module bpwm_timebase #(
  parameter int PER_W  = 8,
  parameter int FRAC_W = 2,
  localparam int CW    = PER_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  output logic [CW-1:0]    cnt_o,
  output logic             wrap_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == {period_i, {FRAC_W{1'b1}}});
  assign wrap_o = en_i & tick_i & at_end;
  assign cnt_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = at_end ? '0 : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bpwm_shadow.sv
module bpwm_shadow
  import bpwm_pkg::*;
#(
  parameter int DUTY_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                wrap_i,
  input  logic [DUTY_W-1:0]   duty_i,
  input  out_mode_e           mode_i,
  input  logic                dir_i,
  input  logic                pol_i,
  input  logic [NUM_PINS-1:0] steer_i,
  output logic                running_o,
  output logic [DUTY_W-1:0]   duty_o,
  output out_mode_e           mode_o,
  output logic                dir_o,
  output logic                pol_o,
  output logic [NUM_PINS-1:0] steer_o
);
  logic load;
  logic run_d;

  assign load  = ~en_i | wrap_i;
  assign run_d = en_i & (running_o | wrap_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running_o <= 1'b0;
    else        running_o <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_o  <= '0;
      mode_o  <= MODE_SINGLE;
      dir_o   <= 1'b0;
      pol_o   <= 1'b0;
      steer_o <= '0;
    end else if (load) begin
      duty_o  <= duty_i;
      mode_o  <= mode_i;
      dir_o   <= dir_i;
      pol_o   <= pol_i;
      steer_o <= steer_i;
    end
  end
endmodule

// File: rtl/bpwm_outctl.sv
module bpwm_outctl
  import bpwm_pkg::*;
#(
  parameter int DUTY_W = 10
) (
  input  logic                running_i,
  input  logic [DUTY_W-1:0]   cnt_i,
  input  logic [DUTY_W-1:0]   duty_i,
  input  out_mode_e           mode_i,
  input  logic                dir_i,
  input  logic                pol_i,
  input  logic [NUM_PINS-1:0] steer_i,
  output logic [NUM_PINS-1:0] pins_o
);
  logic                below;
  logic                lvl;
  logic [NUM_PINS-1:0] drive;

  assign below = (cnt_i < duty_i);
  assign lvl   = running_i & below;

  always_comb begin
    drive = '0;
    unique case (mode_i)
      MODE_SINGLE: drive[0] = lvl;
      MODE_HALF: begin
        drive[0] = lvl;
        drive[1] = running_i & ~below;
      end
      MODE_FULL: begin
        if (dir_i) begin
          drive[2] = running_i;
          drive[1] = lvl;
        end else begin
          drive[0] = running_i;
          drive[3] = lvl;
        end
      end
      MODE_STEER: drive = steer_i & {NUM_PINS{lvl}};
      default: drive = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign pins_o[g] = drive[g] ^ pol_i;
  end
endmodule

// File: rtl/bridge_pwm.sv
module bridge_pwm
  import bpwm_pkg::*;
#(
  parameter int PER_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = PER_W + FRAC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                en_i,
  input  logic [PER_W-1:0]    period_i,
  input  logic [PER_W-1:0]    duty_hi_i,
  input  logic [FRAC_W-1:0]   duty_lo_i,
  input  logic [1:0]          mode_i,
  input  logic                dir_i,
  input  logic                pol_i,
  input  logic [NUM_PINS-1:0] steer_i,
  output logic [NUM_PINS-1:0] pwm_o,
  output logic                match_o
);
  logic                rst_meta_n, rst_sync_n;
  logic [DUTY_W-1:0]   cnt_q;
  logic                wrap;
  logic                running_q;
  logic [DUTY_W-1:0]   duty_q;
  out_mode_e           mode_q;
  logic                dir_q, pol_q;
  logic [NUM_PINS-1:0] steer_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  bpwm_timebase #(.PER_W(PER_W), .FRAC_W(FRAC_W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_i     (en_i),
    .tick_i   (tick_i),
    .period_i (period_i),
    .cnt_o    (cnt_q),
    .wrap_o   (wrap)
  );

  bpwm_shadow #(.DUTY_W(DUTY_W)) u_sh (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en_i      (en_i),
    .wrap_i    (wrap),
    .duty_i    ({duty_hi_i, duty_lo_i}),
    .mode_i    (out_mode_e'(mode_i)),
    .dir_i     (dir_i),
    .pol_i     (pol_i),
    .steer_i   (steer_i),
    .running_o (running_q),
    .duty_o    (duty_q),
    .mode_o    (mode_q),
    .dir_o     (dir_q),
    .pol_o     (pol_q),
    .steer_o   (steer_q)
  );

  bpwm_outctl #(.DUTY_W(DUTY_W)) u_oc (
    .running_i (running_q),
    .cnt_i     (cnt_q),
    .duty_i    (duty_q),
    .mode_i    (mode_q),
    .dir_i     (dir_q),
    .pol_i     (pol_q),
    .steer_i   (steer_q),
    .pins_o    (pwm_o)
  );

  assign match_o = wrap;
endmodule

// File: rtl/bpwm_checker.sv
module bpwm_checker #(
  parameter int DUTY_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              tick_i,
  input logic              pol_i,
  input logic [3:0]        pwm_o,
  input logic              match_o,
  input logic [DUTY_W-1:0] cnt,
  input logic [1:0]        mode_sh,
  input logic              pol_sh
);
  assert_match_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> (en_i && tick_i));

  assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> (cnt == '0));

  assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i) |=> (cnt == $past(cnt)));

  assert_dark_at_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_i) |-> (pwm_o == {4{pol_sh}}));

  assert_idle_inactive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ((pwm_o == {4{$past(pol_i)}}) && !match_o && (cnt == '0)));

  assert_no_shoot_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sh == 2'b10) |-> !((pwm_o[0] ^ pol_sh) && (pwm_o[2] ^ pol_sh)));
endmodule

bind bridge_pwm bpwm_checker #(.DUTY_W(DUTY_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .en_i    (en_i),
  .tick_i  (tick_i),
  .pol_i   (pol_i),
  .pwm_o   (pwm_o),
  .match_o (match_o),
  .cnt     (cnt_q),
  .mode_sh (mode_q),
  .pol_sh  (pol_q)
);

// File: tb/bridge_pwm_tb.sv
module bridge_pwm_tb;
  logic       clk, rst_n, tick_i, en_i, dir_i, pol_i, match_o;
  logic [7:0] period_i, duty_hi_i;
  logic [1:0] duty_lo_i, mode_i;
  logic [3:0] steer_i, pwm_o;

  int checks, fails;
  string phase;

  bridge_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(en_i),
    .period_i(period_i), .duty_hi_i(duty_hi_i), .duty_lo_i(duty_lo_i),
    .mode_i(mode_i), .dir_i(dir_i), .pol_i(pol_i), .steer_i(steer_i),
    .pwm_o(pwm_o), .match_o(match_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference state
  int   m_cnt, m_duty, m_mode, m_last;
  bit   m_run, m_dir, m_pol;
  bit [3:0] m_steer;

  task automatic m_load();
    m_duty  = duty_hi_i * 4 + duty_lo_i;
    m_mode  = mode_i;
    m_dir   = dir_i;
    m_pol   = pol_i;
    m_steer = steer_i;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_duty = 0; m_mode = 0;
      m_dir = 0; m_pol = 0; m_steer = 0;
    end else begin
      m_last = period_i * 4 + 3;
      if (!en_i) begin
        m_cnt = 0; m_run = 0; m_load();
      end else if (tick_i) begin
        if (m_cnt == m_last) begin
          m_cnt = 0; m_run = 1; m_load();
        end else begin
          m_cnt = (m_cnt + 1) % 1024;
        end
      end
    end
  end

  function automatic bit [3:0] exp_pins();
    bit lvl, below;
    bit [3:0] d;
    below = (m_cnt < m_duty);
    lvl   = m_run && below;
    d = 4'b0000;
    case (m_mode)
      0: d[0] = lvl;
      1: begin d[0] = lvl; d[1] = m_run && !below; end
      2: if (m_dir) begin d[2] = m_run; d[1] = lvl; end
         else       begin d[0] = m_run; d[3] = lvl; end
      default: d = m_steer & {4{lvl}};
    endcase
    return d ^ {4{m_pol}};
  endfunction

  function automatic string mode_tag();
    if (!en_i) return "R5";
    if (!m_run) return "R4";
    case (m_mode)
      0: return "R7";
      1: return "R8";
      2: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    bit [3:0] ep;
    bit em;
    ep = exp_pins();
    em = en_i && tick_i && (m_cnt == period_i * 4 + 3);
    checks++;
    if (pwm_o !== ep) begin
      fails++;
      $display("FAIL %s/R2/R3/R6 (phase %s) t=%0t pwm_o got %b exp %b",
               mode_tag(), phase, $time, pwm_o, ep);
    end
    checks++;
    if (match_o !== em) begin
      fails++;
      $display("FAIL R1 (phase %s) t=%0t match_o got %b exp %b",
               phase, $time, match_o, em);
    end
  end

  task automatic run(input int n, input int div);
    for (int i = 0; i < n; i++) begin
      tick_i = (i % div == 0);
      @(posedge clk); #1;
    end
  endtask

  task automatic set_duty(input int d);
    duty_hi_i = d[9:2];
    duty_lo_i = d[1:0];
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    phase = "R5 reset";
    rst_n = 1'b0; tick_i = 1'b1; en_i = 1'b0; period_i = 8'd3;
    set_duty(6); mode_i = 2'b00; dir_i = 1'b0; pol_i = 1'b0; steer_i = 4'b0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    run(6, 1);

    // R4: deferred start; R7 single
    phase = "R4 R7 single";
    en_i = 1'b1;
    run(40, 1);

    // R3: mid-period writes wait for boundary
    phase = "R3 mid-period change";
    run(5, 1);
    set_duty(9); mode_i = 2'b01;
    run(40, 1);

    phase = "R8 half";
    set_duty(3);
    run(34, 1);

    // R9 both directions, direction changed mid-period
    phase = "R9 full fwd";
    mode_i = 2'b10; dir_i = 1'b0; set_duty(10);
    run(37, 1);
    phase = "R9 full rev";
    dir_i = 1'b1;
    run(40, 1);

    phase = "R10 steer 1010";
    mode_i = 2'b11; steer_i = 4'b1010; set_duty(7);
    run(40, 1);
    phase = "R10 steer 0101";
    steer_i = 4'b0101;
    run(40, 1);

    phase = "R6 active low";
    pol_i = 1'b1; steer_i = 4'b1111;
    run(40, 1);

    phase = "R2 duty zero";
    set_duty(0);
    run(40, 1);
    phase = "R2 duty full";
    set_duty(1023); mode_i = 2'b01;
    run(40, 1);

    phase = "R1 sparse ticks";
    period_i = 8'd5; set_duty(13); mode_i = 2'b00;
    run(160, 3);

    phase = "R5 disable mid-run";
    run(7, 1);
    en_i = 1'b0;
    run(10, 1);
    pol_i = 1'b0;
    run(5, 1);

    phase = "R4 re-enable";
    en_i = 1'b1; mode_i = 2'b10; dir_i = 1'b0; set_duty(20);
    run(60, 1);

    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule